// File: doc/BRIEF.md
# Lazy NZCV Flag Evaluator

This block rebuilds the four processor condition flags (negative, zero, carry, overflow) from a saved record of the most recent flag-setting operation. It does not sit next to an ALU. Software-visible state keeps only a 4-bit operation code and three 32-bit dependency words. When the flags are needed, this block works them out from that record.

Each operation code gives the three words a different meaning. For add and subtract, the words are the two operands. For the carry-chained forms, word 3 also supplies the previous carry. For logical operations, words 2 and 3 supply the shifter carry-out and the previous overflow bit. For the 32- and 64-bit multiplies, word 3 supplies the previous carry and overflow bits, which pass through unchanged.

A request strobe loads one record. On the next clock edge the block presents three results: the packed flags word, a carry-only bit and an overflow-only bit. A response strobe marks them as valid. Between requests the outputs hold their last value.

Top module: `lazy_flags_eval`

## Requirements
- R1: The packed flags word carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bits 27:0 are always zero.
- R2: Operation code 0 (copy) returns bits 31:28 of word 1 in bits 31:28, with every lower bit zero. Words 2 and 3 have no effect.
- R3: Operation code 1 (add) forms word1 + word2. C is the carry out of bit 31. V is set when both operands have the same sign and the sum's sign differs from it.
- R4: Operation code 2 (subtract) forms word1 + ~word2 + 1. C is set when there is no borrow. V is set when word1 and ~word2 have the same sign and the result's sign differs from it.
- R5: Operation code 3 (add with carry) forms word1 + word2 + word3[0], with the same C and V rules as R3.
- R6: Operation code 4 (subtract with carry) forms word1 + ~word2 + word3[0], with the same C and V rules as R4.
- R7: Operation code 5 (logical) takes N and Z from word 1. C is word2[0] and V is word3[0].
- R8: Operation code 6 (32-bit multiply) takes N and Z from word 1. C is word3[1] and V is word3[0].
- R9: Operation code 7 (64-bit multiply) sets N to bit 31 of word 2. Z is set only when word 1 and word 2 are both zero. C is word3[1] and V is word3[0].
- R10: An operation code from 8 to 15 gives an all-zero flags word. It also raises the illegal-operation output in the cycle its result appears. That output is low in the following cycle unless another illegal request was made.
- R11: The carry-only output always equals bit 29 of the flags word, and the overflow-only output always equals bit 28.
- R12: Results and the response strobe appear one clock after the request strobe. Without a request, the outputs keep their values and the response strobe is low.
- R13: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; loads one operation record |
| op_code | input | 4 | Operation code of the recorded operation |
| dep1 | input | 32 | Dependency word 1 |
| dep2 | input | 32 | Dependency word 2 |
| dep3 | input | 32 | Dependency word 3 |
| flags_word | output | 32 | Packed N,Z,C,V in bits 31:28, zero below |
| carry_out | output | 1 | C flag alone |
| ovf_out | output | 1 | V flag alone |
| rsp_valid | output | 1 | Result valid, one cycle after a request |
| bad_op | output | 1 | Illegal operation code seen in the answered request |

## Verification
The hardest cases to reach are the overflow boundaries of the subtract forms. There, V depends on the sign of the inverted right operand rather than of the operand itself. C must read as "no borrow", and the chained forms must also honour the incoming carry. The vector table aims straight at these cases: the most negative value minus one, equal operands with the old carry both clear and set, and an all-ones add with carry-in. A back-to-back request pair and a held-input phase show that each answer belongs to its own request. A second illegal-code check confirms that the illegal indication falls again.

// File: rtl/lflag_pkg.sv
package lflag_pkg;

    localparam int LF_FLAG_BITS = 4;

    typedef enum logic [3:0] {
        LF_COPY  = 4'd0,
        LF_ADD   = 4'd1,
        LF_SUB   = 4'd2,
        LF_ADC   = 4'd3,
        LF_SBB   = 4'd4,
        LF_LOGIC = 4'd5,
        LF_MUL   = 4'd6,
        LF_MULL  = 4'd7
    } lf_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam nzcv_t LF_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    // Codes 8..15 are not defined.
    function automatic logic lf_legal(input logic [3:0] code);
        return (code[3] == 1'b0);
    endfunction

    // Subtract forms use the inverted right operand.
    function automatic logic lf_invert_rhs(input logic [3:0] code);
        return (code == LF_SUB) || (code == LF_SBB);
    endfunction

    function automatic logic lf_is_arith(input logic [3:0] code);
        return (code == LF_ADD) || (code == LF_SUB) ||
               (code == LF_ADC) || (code == LF_SBB);
    endfunction

endpackage

// File: rtl/lflag_addsub.sv
module lflag_addsub
    import lflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         inv_rhs,
    input  logic         cin,
    output nzcv_t        flags
);
    localparam int SUM_W = W + 1;

    logic [W-1:0]     rhs_eff;
    logic [SUM_W-1:0] total;
    logic [W-1:0]     res;

    always_comb begin
        rhs_eff = inv_rhs ? ~rhs : rhs;
        total   = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin};
        res     = total[W-1:0];
        flags.n = res[W-1];
        flags.z = (res == '0);
        flags.c = total[W];
        flags.v = (lhs[W-1] == rhs_eff[W-1]) && (res[W-1] != lhs[W-1]);
    end

endmodule

// File: rtl/lflag_direct.sv
module lflag_direct
    import lflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   code,
    input  logic [W-1:0] w1,
    input  logic [W-1:0] w2,
    input  logic [W-1:0] w3,
    output nzcv_t        flags
);
    logic lf_unused_w3;
    assign lf_unused_w3 = ^w3[W-1:2];

    always_comb begin
        flags = LF_CLEAR;
        unique case (code)
            LF_COPY: begin
                flags.n = w1[W-1];
                flags.z = w1[W-2];
                flags.c = w1[W-3];
                flags.v = w1[W-4];
            end
            LF_LOGIC: begin
                flags.n = w1[W-1];
                flags.z = (w1 == '0);
                flags.c = w2[0];
                flags.v = w3[0];
            end
            LF_MUL: begin
                flags.n = w1[W-1];
                flags.z = (w1 == '0);
                flags.c = w3[1];
                flags.v = w3[0];
            end
            LF_MULL: begin
                flags.n = w2[W-1];
                flags.z = (w1 == '0) && (w2 == '0);
                flags.c = w3[1];
                flags.v = w3[0];
            end
            default: flags = LF_CLEAR;
        endcase
    end

endmodule

// File: rtl/lflag_select.sv
module lflag_select
    import lflag_pkg::*;
(
    input  logic [3:0] code,
    input  nzcv_t      arith_f,
    input  nzcv_t      direct_f,
    output nzcv_t      chosen,
    output logic       illegal
);
    always_comb begin
        illegal = !lf_legal(code);
        if (illegal)
            chosen = LF_CLEAR;
        else if (lf_is_arith(code))
            chosen = arith_f;
        else
            chosen = direct_f;
    end

endmodule

// File: rtl/lazy_flags_eval.sv
module lazy_flags_eval
    import lflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] dep1,
    input  logic [W-1:0] dep2,
    input  logic [W-1:0] dep3,
    output logic [W-1:0] flags_word,
    output logic         carry_out,
    output logic         ovf_out,
    output logic         rsp_valid,
    output logic         bad_op
);
    localparam int LOW_W = W - LF_FLAG_BITS;

    nzcv_t arith_f;
    nzcv_t direct_f;
    nzcv_t next_f;
    nzcv_t held_f;
    logic  illegal;
    logic  cin;

    // Carry-in: plain add 0, plain subtract 1, chained forms take old C.
    always_comb begin
        unique case (op_code)
            LF_SUB:         cin = 1'b1;
            LF_ADC, LF_SBB: cin = dep3[0];
            default:        cin = 1'b0;
        endcase
    end

    lflag_addsub #(.W(W)) u_addsub (
        .lhs     (dep1),
        .rhs     (dep2),
        .inv_rhs (lf_invert_rhs(op_code)),
        .cin     (cin),
        .flags   (arith_f)
    );

    lflag_direct #(.W(W)) u_direct (
        .code  (op_code),
        .w1    (dep1),
        .w2    (dep2),
        .w3    (dep3),
        .flags (direct_f)
    );

    lflag_select u_select (
        .code     (op_code),
        .arith_f  (arith_f),
        .direct_f (direct_f),
        .chosen   (next_f),
        .illegal  (illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_f    <= LF_CLEAR;
            rsp_valid <= 1'b0;
            bad_op    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            bad_op    <= req_valid && illegal;
            if (req_valid)
                held_f <= next_f;
        end
    end

    assign flags_word = {held_f, {LOW_W{1'b0}}};
    assign carry_out  = held_f.c;
    assign ovf_out    = held_f.v;

endmodule

// File: rtl/lflag_chk.sv
module lflag_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] dep1,
    input logic [W-1:0] flags_word,
    input logic         carry_out,
    input logic         ovf_out,
    input logic         rsp_valid,
    input logic         bad_op
);
    p_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
        flags_word[W-5:0] == '0);

    p_copy_top_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_code == 4'd0) |=> flags_word[W-1:W-4] == $past(dep1[W-1:W-4]));

    p_bad_raise_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_code[3]) |=> bad_op);

    p_bad_zero_r10: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> flags_word == '0);

    p_carry_alias_r11: assert property (@(posedge clk) disable iff (rst)
        carry_out == flags_word[W-3]);

    p_ovf_alias_r11: assert property (@(posedge clk) disable iff (rst)
        ovf_out == flags_word[W-4]);

    p_rsp_follow_r12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && $stable(flags_word)));

endmodule

bind lazy_flags_eval lflag_chk #(.W(W)) u_chk (.*);

// File: tb/lazy_flags_eval_tb.sv
module lazy_flags_eval_tb;

    localparam int VW = 4 + 32 * 4 + 1;

    // {op, dep1, dep2, dep3, expected flags word, expected bad_op}
    localparam logic [VW-1:0] VEC [22] = '{
        {4'd0, 32'hA5FF_FFFF, 32'h0, 32'h0, 32'hA000_0000, 1'b0}, // R2
        {4'd0, 32'h0FFF_FFFF, 32'h0, 32'h0, 32'h0000_0000, 1'b0}, // R2
        {4'd1, 32'h7FFF_FFFF, 32'h1, 32'h0, 32'h9000_0000, 1'b0}, // R3
        {4'd1, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h6000_0000, 1'b0}, // R3
        {4'd1, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h7000_0000, 1'b0}, // R3
        {4'd2, 32'h5, 32'h3, 32'h0, 32'h2000_0000, 1'b0},         // R4
        {4'd2, 32'h3, 32'h5, 32'h0, 32'h8000_0000, 1'b0},         // R4
        {4'd2, 32'h8000_0000, 32'h1, 32'h0, 32'h3000_0000, 1'b0}, // R4
        {4'd2, 32'h7, 32'h7, 32'h0, 32'h6000_0000, 1'b0},         // R4
        {4'd3, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h6000_0000, 1'b0}, // R5
        {4'd3, 32'h1, 32'h1, 32'h0, 32'h0000_0000, 1'b0},         // R5
        {4'd4, 32'h5, 32'h5, 32'h0, 32'h8000_0000, 1'b0},         // R6
        {4'd4, 32'h5, 32'h5, 32'h1, 32'h6000_0000, 1'b0},         // R6
        {4'd5, 32'h0, 32'h1, 32'h1, 32'h7000_0000, 1'b0},         // R7
        {4'd5, 32'h8000_0000, 32'h0, 32'h0, 32'h8000_0000, 1'b0}, // R7
        {4'd6, 32'h1234_5678, 32'h0, 32'h2, 32'h2000_0000, 1'b0}, // R8
        {4'd6, 32'h0, 32'h0, 32'h1, 32'h5000_0000, 1'b0},         // R8
        {4'd7, 32'h0, 32'h0, 32'h3, 32'h7000_0000, 1'b0},         // R9
        {4'd7, 32'h0, 32'h8000_0000, 32'h0, 32'h8000_0000, 1'b0}, // R9
        {4'd7, 32'h1, 32'h0, 32'h0, 32'h0000_0000, 1'b0},         // R9
        {4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3, 32'h0, 1'b1}, // R10
        {4'd15, 32'hF000_0000, 32'h0, 32'h3, 32'h0, 1'b1}         // R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [3:0]  op_code;
    logic [31:0] dep1, dep2, dep3;
    logic [31:0] flags_word;
    logic        carry_out, ovf_out, rsp_valid, bad_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lazy_flags_eval u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .op_code    (op_code),
        .dep1       (dep1),
        .dep2       (dep2),
        .dep3       (dep3),
        .flags_word (flags_word),
        .carry_out  (carry_out),
        .ovf_out    (ovf_out),
        .rsp_valid  (rsp_valid),
        .bad_op     (bad_op)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c);
        @(negedge clk);
        req_valid = 1'b1;
        op_code   = op;
        dep1      = a;
        dep2      = b;
        dep3      = c;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; op_code = '0;
        dep1 = '0; dep2 = '0; dep3 = '0;
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 flags", flags_word, 32'h0);
        check("R13 strobes", {28'h0, carry_out, ovf_out, rsp_valid, bad_op}, 32'h0);
        rst = 1'b0;

        // Table walk: each request answered on the next edge.
        for (int i = 0; i < 22; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            issue(v[132:129], v[128:97], v[96:65], v[64:33]);
            idle();
            check("R2-9 table flags", flags_word, v[32:1]);
            check("R1 low bits", {4'h0, flags_word[27:0]}, 32'h0);
            check("R11 carry alias", {31'h0, carry_out}, {31'h0, v[30]});
            check("R11 ovf alias", {31'h0, ovf_out}, {31'h0, v[29]});
            check("R12 rsp_valid", {31'h0, rsp_valid}, 32'h1);
            check("R10 bad_op", {31'h0, bad_op}, {31'h0, v[0]});
        end

        // R10: illegal indication drops with no further request
        @(negedge clk);
        check("R10 bad_op falls", {31'h0, bad_op}, 32'h0);

        // R12: hold - set a known result then wiggle inputs without strobe
        issue(4'd1, 32'h7FFF_FFFF, 32'h1, 32'h0);
        idle();
        op_code = 4'd0; dep1 = 32'hF000_0000;
        @(negedge clk);
        check("R12 hold flags", flags_word, 32'h9000_0000);
        check("R12 no rsp", {31'h0, rsp_valid}, 32'h0);

        // R12: back-to-back requests, each answered in turn
        issue(4'd5, 32'h0, 32'h0, 32'h1);
        issue(4'd6, 32'h8000_0000, 32'h0, 32'h2);
        check("R7 back-to-back first", flags_word, 32'h5000_0000);
        idle();
        check("R8 back-to-back second", flags_word, 32'hA000_0000);

        // R2: words 2 and 3 ignored by copy
        issue(4'd0, 32'h4000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle();
        check("R2 ignores words 2,3", flags_word, 32'h4000_0000);

        // R13: reset clears a held result
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R13 after reset", flags_word, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule